// File: doc/BRIEF.md
# Transponder Read Stream Sequencer

This block decides which stored word, and which bit of it, the load modulator sends next. After power-on it waits out a configuration-loading interval with modulation off. It then sends the user blocks one bit per bit-clock strobe, from block 1 up to the configured last block, and wraps around. Bit 0 of each word is the lock bit and is skipped. Optional synchronisation patterns can be put in front of every block and after the last one.

The block also gates the modulator. In answer-on-request operation it stays silent until the write decoder reports a wake-up. A stop command silences it until the next reset. When the write path reports a result, reading restarts at a block that depends on that result: block 1 after an error or a wake-up, and the addressed block after programming or an aborted programming. The mode word in use is presented on `cfg_o` for the encoder. It is refreshed from the stored configuration at each block boundary. The one exception is the block sent right after programming, which still uses the previous mode.

Configuration word layout (`cfg_i`, `cfg_o`, with `ADDR_W` = 3): bits [2:0] give the last block (MAXB), bit 3 enables the block terminator, bit 4 enables the sequence terminator, and bit 5 selects answer-on-request.

Top module: `rd_stream_seq`

## Requirements
- R1: After reset, `mod_en_o` stays low for INIT_CYCLES (256) clocks while the configuration loads. Any cycle with `wr_mode_i` high during this interval restarts the count from zero.
- R2: At the end of loading, `cfg_i` is captured into `cfg_o`. If answer-on-request is clear, transmission starts in the next cycle at block 1, bit 1, or at block 0 when MAXB is 0.
- R3: While transmitting a block, `bit_idx_o` runs from 1 to 32 and advances only on a `bit_stb_i` strobe. `data_o` equals `rd_word_i[bit_idx_o]`, so bit 0 is never sent.
- R4: After bit 32 of block MAXB, or of any block at or above MAXB, the next block is 1. After any lower block, the next block is the following one. When MAXB is 0, block 0 repeats.
- R5: At each block boundary, `cfg_o` is reloaded from `cfg_i`, and the next block and its terminators are chosen from the newly loaded value.
- R6: With the block terminator enabled, each block is preceded by a pattern of three bit periods, `data_o` = 1, 0, 0. `term_o` is high for all three periods.
- R7: With the sequence terminator enabled and MAXB not 0, two extra terminator patterns precede block 1 when the stream wraps. These come in addition to any block terminator.
- R8: With answer-on-request set, modulation stays off after loading until `wr_wake_i`, which starts block 1 with the configuration reloaded. `wr_stop_i` while waiting silences the block until reset.
- R9: `wr_mode_i` high while transmitting turns `mod_en_o` off in the next cycle and freezes the position. A stop result leaves `mod_en_o` low until reset.
- R10: A write-error or wake-up result at the end of write mode restarts at block 1, bit 1, with `cfg_o` reloaded.
- R11: A programming-done result restarts at `prog_addr_i`, preceded by one terminator if the mode in use enables either terminator. `cfg_o` keeps the old mode until that block ends.
- R12: A programming-abort result restarts at `prog_addr_i` with `cfg_o` reloaded, preceded by a terminator only if the reloaded mode enables the block terminator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Field clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| bit_stb_i | input | 1 | One-cycle strobe per bit period |
| wr_mode_i | input | 1 | Field gap / write mode in progress |
| wr_stop_i | input | 1 | Write result: stop command |
| wr_wake_i | input | 1 | Write result: valid wake-up |
| wr_err_i | input | 1 | Write result: decoding error |
| prog_done_i | input | 1 | Programming finished |
| prog_abort_i | input | 1 | Programming aborted (supply low or block locked) |
| prog_addr_i | input | ADDR_W | Block addressed by the write |
| cfg_i | input | ADDR_W+3 | Stored configuration word |
| rd_word_i | input | DATA_BITS+1 | Word at `blk_addr_o`, bit 0 is the lock bit |
| blk_addr_o | output | ADDR_W | Block being sent |
| bit_idx_o | output | $clog2(DATA_BITS+1) | Bit being sent |
| data_o | output | 1 | Serial bit for the encoder |
| term_o | output | 1 | Terminator pattern in progress |
| mod_en_o | output | 1 | Modulation enable |
| cfg_o | output | ADDR_W+3 | Mode word in use |

## Verification
The checks assume that the write decoder raises at most one result pulse per cycle, and only while the block is in write mode or waiting for a wake-up. They also assume `bit_stb_i` is a single-cycle pulse. The stimulus keeps to these rules. Each result is sent as one pulse on the last cycle of a write-mode window, and strobes come from a fixed divider. Strobes keep running through write mode and reset, so the frozen position has to be confirmed rather than taken for granted.

// File: rtl/rd_seq_pkg.sv
package rd_seq_pkg;
  typedef enum logic [2:0] {
    S_INIT  = 3'd0,
    S_WAIT  = 3'd1,
    S_RUN   = 3'd2,
    S_WRITE = 3'd3,
    S_STOP  = 3'd4
  } seq_state_e;

  // flag offsets above the last-block field
  localparam int unsigned CFG_BT_OFS  = 0;
  localparam int unsigned CFG_ST_OFS  = 1;
  localparam int unsigned CFG_AOR_OFS = 2;
  localparam int unsigned TERM_PERIODS = 3;
endpackage

// File: rtl/rd_seq_init_timer.sv
module rd_seq_init_timer #(
  parameter int unsigned INIT_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == CNT_W'(INIT_CYCLES - 1));
  assign done_o = en_i && !clr_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !at_end)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rd_seq_blk_next.sv
module rd_seq_blk_next #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] blk_i,
  input  logic [ADDR_W-1:0] maxb_i,
  input  logic              bt_en_i,
  input  logic              st_en_i,
  output logic [ADDR_W-1:0] nxt_blk_o,
  output logic [1:0]        nxt_terms_o
);
  logic wrap;

  assign wrap = (maxb_i != '0) && (blk_i >= maxb_i);

  always_comb begin
    if (maxb_i == '0)  nxt_blk_o = '0;
    else if (wrap)     nxt_blk_o = ADDR_W'(1);
    else               nxt_blk_o = blk_i + 1'b1;
    nxt_terms_o = {1'b0, bt_en_i} + ((wrap && st_en_i) ? 2'd2 : 2'd0);
  end
endmodule

// File: rtl/rd_seq_bit_pos.sv
module rd_seq_bit_pos #(
  parameter int unsigned DATA_BITS = 32,
  localparam int unsigned BIDX_W = $clog2(DATA_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        terms_i,
  input  logic              adv_i,
  output logic              term_act_o,
  output logic              term_first_o,
  output logic [BIDX_W-1:0] bit_idx_o,
  output logic              blk_end_o
);
  import rd_seq_pkg::*;

  logic [1:0]        terms_q;
  logic [1:0]        tpos_q;
  logic [BIDX_W-1:0] idx_q;

  assign term_act_o   = (terms_q != 2'd0);
  assign term_first_o = (tpos_q == 2'd0);
  assign bit_idx_o    = idx_q;
  assign blk_end_o    = adv_i && !term_act_o && (idx_q == BIDX_W'(DATA_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      terms_q <= 2'd0;
      tpos_q  <= 2'd0;
      idx_q   <= BIDX_W'(1);
    end else if (load_i) begin
      terms_q <= terms_i;
      tpos_q  <= 2'd0;
      idx_q   <= BIDX_W'(1);
    end else if (adv_i) begin
      if (term_act_o) begin
        if (tpos_q == 2'(TERM_PERIODS - 1)) begin
          tpos_q  <= 2'd0;
          terms_q <= terms_q - 1'b1;
        end else begin
          tpos_q <= tpos_q + 1'b1;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rd_stream_seq.sv
module rd_stream_seq #(
  parameter int unsigned N_BLOCKS    = 8,
  parameter int unsigned DATA_BITS   = 32,
  parameter int unsigned INIT_CYCLES = 256,
  localparam int unsigned ADDR_W = $clog2(N_BLOCKS),
  localparam int unsigned CFG_W  = ADDR_W + 3,
  localparam int unsigned WORD_W = DATA_BITS + 1,
  localparam int unsigned BIDX_W = $clog2(DATA_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              wr_mode_i,
  input  logic              wr_stop_i,
  input  logic              wr_wake_i,
  input  logic              wr_err_i,
  input  logic              prog_done_i,
  input  logic              prog_abort_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic [BIDX_W-1:0] bit_idx_o,
  output logic              data_o,
  output logic              term_o,
  output logic              mod_en_o,
  output logic [CFG_W-1:0]  cfg_o
);
  import rd_seq_pkg::*;

  localparam int unsigned BT_B  = ADDR_W + CFG_BT_OFS;
  localparam int unsigned ST_B  = ADDR_W + CFG_ST_OFS;
  localparam int unsigned AOR_B = ADDR_W + CFG_AOR_OFS;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] blk_q, blk_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;

  logic              init_done;
  logic              running;
  logic              adv;
  logic              pos_load;
  logic [1:0]        pos_terms;
  logic              term_act, term_first, blk_end;
  logic [BIDX_W-1:0] bit_idx;
  logic [ADDR_W-1:0] nxt_blk, first_blk;
  logic [1:0]        nxt_terms;

  assign running   = (state_q == S_RUN);
  assign adv       = running && !wr_mode_i && bit_stb_i;
  assign first_blk = (cfg_i[ADDR_W-1:0] == '0) ? '0 : ADDR_W'(1);

  rd_seq_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_INIT),
    .clr_i  (wr_mode_i),
    .done_o (init_done)
  );

  rd_seq_blk_next #(.ADDR_W(ADDR_W)) u_next (
    .blk_i       (blk_q),
    .maxb_i      (cfg_i[ADDR_W-1:0]),
    .bt_en_i     (cfg_i[BT_B]),
    .st_en_i     (cfg_i[ST_B]),
    .nxt_blk_o   (nxt_blk),
    .nxt_terms_o (nxt_terms)
  );

  rd_seq_bit_pos #(.DATA_BITS(DATA_BITS)) u_pos (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (pos_load),
    .terms_i      (pos_terms),
    .adv_i        (adv),
    .term_act_o   (term_act),
    .term_first_o (term_first),
    .bit_idx_o    (bit_idx),
    .blk_end_o    (blk_end)
  );

  always_comb begin
    state_d   = state_q;
    blk_d     = blk_q;
    cfg_d     = cfg_q;
    pos_load  = 1'b0;
    pos_terms = 2'd0;
    unique case (state_q)
      S_INIT: begin
        if (init_done) begin
          cfg_d = cfg_i;
          if (cfg_i[AOR_B]) begin
            state_d = S_WAIT;
          end else begin
            state_d   = S_RUN;
            blk_d     = first_blk;
            pos_load  = 1'b1;
            pos_terms = {1'b0, cfg_i[BT_B]};
          end
        end
      end
      S_WAIT: begin
        if (wr_stop_i) begin
          state_d = S_STOP;
        end else if (wr_wake_i) begin
          state_d   = S_RUN;
          cfg_d     = cfg_i;
          blk_d     = first_blk;
          pos_load  = 1'b1;
          pos_terms = {1'b0, cfg_i[BT_B]};
        end
      end
      S_RUN: begin
        if (wr_mode_i) begin
          state_d = S_WRITE;
        end else if (blk_end) begin
          cfg_d     = cfg_i;
          blk_d     = nxt_blk;
          pos_load  = 1'b1;
          pos_terms = nxt_terms;
        end
      end
      S_WRITE: begin
        if (wr_stop_i) begin
          state_d = S_STOP;
        end else if (wr_err_i || wr_wake_i) begin
          state_d   = S_RUN;
          cfg_d     = cfg_i;
          blk_d     = first_blk;
          pos_load  = 1'b1;
          pos_terms = {1'b0, cfg_i[BT_B]};
        end else if (prog_abort_i) begin
          state_d   = S_RUN;
          cfg_d     = cfg_i;
          blk_d     = prog_addr_i;
          pos_load  = 1'b1;
          pos_terms = {1'b0, cfg_i[BT_B]};
        end else if (prog_done_i) begin
          // old mode stays in force for the re-sent block
          state_d   = S_RUN;
          blk_d     = prog_addr_i;
          pos_load  = 1'b1;
          pos_terms = {1'b0, cfg_q[BT_B] | cfg_q[ST_B]};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_INIT;
      blk_q   <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      blk_q   <= blk_d;
      cfg_q   <= cfg_d;
    end
  end

  assign blk_addr_o = blk_q;
  assign bit_idx_o  = bit_idx;
  assign mod_en_o   = running;
  assign term_o     = running && term_act;
  assign data_o     = running && (term_act ? term_first : rd_word_i[bit_idx]);
  assign cfg_o      = cfg_q;
endmodule

// File: rtl/rd_stream_seq_chk.sv
module rd_stream_seq_chk #(
  parameter int unsigned DATA_BITS = 32,
  parameter int unsigned BIDX_W    = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_stb_i,
  input logic              wr_mode_i,
  input logic [BIDX_W-1:0] bit_idx_o,
  input logic              data_o,
  input logic              term_o,
  input logic              mod_en_o,
  input logic              stopped_i
);
  assert_idx_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_o |-> (bit_idx_o >= BIDX_W'(1)) && (bit_idx_o <= BIDX_W'(DATA_BITS)));

  assert_idx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_o && $past(mod_en_o) && !$past(bit_stb_i) && !$past(wr_mode_i))
      |-> $stable(bit_idx_o));

  assert_term_starts_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> data_o);

  assert_mod_off_in_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_o && wr_mode_i) |=> !mod_en_o);

  assert_stop_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_i |=> (stopped_i && !mod_en_o));
endmodule

bind rd_stream_seq rd_stream_seq_chk #(
  .DATA_BITS (DATA_BITS),
  .BIDX_W    (BIDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_stb_i (bit_stb_i),
  .wr_mode_i (wr_mode_i),
  .bit_idx_o (bit_idx_o),
  .data_o    (data_o),
  .term_o    (term_o),
  .mod_en_o  (mod_en_o),
  .stopped_i (state_q == rd_seq_pkg::S_STOP)
);

// File: tb/rd_stream_seq_tb.sv
`timescale 1ns/1ps
module rd_stream_seq_tb;
  localparam int INIT = 256;
  localparam int NB   = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b0, wr_mode = 1'b0;
  logic       ev_stop = 1'b0, ev_wake = 1'b0, ev_err = 1'b0, ev_done = 1'b0, ev_abort = 1'b0;
  logic [2:0] paddr = '0;
  logic [5:0] cfg = '0;
  logic [32:0] mem [8];
  logic [32:0] rd_word;
  logic [2:0] blk_addr;
  logic [5:0] bit_idx;
  logic       data, term, mod_en;
  logic [5:0] cfg_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string req = "R1";

  always #10 clk = ~clk;

  assign rd_word = mem[blk_addr];

  rd_stream_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .wr_mode_i(wr_mode),
    .wr_stop_i(ev_stop), .wr_wake_i(ev_wake), .wr_err_i(ev_err),
    .prog_done_i(ev_done), .prog_abort_i(ev_abort), .prog_addr_i(paddr),
    .cfg_i(cfg), .rd_word_i(rd_word), .blk_addr_o(blk_addr), .bit_idx_o(bit_idx),
    .data_o(data), .term_o(term), .mod_en_o(mod_en), .cfg_o(cfg_o)
  );

  // reference model: 0 init, 1 wait, 2 run, 3 write, 4 stopped
  int ms, mcnt, mblk, mtl, mtp, mbi;
  logic [5:0] mcfg;

  task automatic m_go(input int b, input int t);
    ms = 2; mblk = b; mtl = t; mtp = 0; mbi = 1;
  endtask

  function automatic int first_of(input logic [5:0] c);
    return (c[2:0] == 3'd0) ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mblk = 0; mtl = 0; mtp = 0; mbi = 1; mcfg = '0;
    end else begin
      case (ms)
        0: if (wr_mode) mcnt = 0;
           else if (mcnt == INIT - 1) begin
             mcfg = cfg;
             if (cfg[5]) ms = 1; else m_go(first_of(cfg), int'(cfg[3]));
           end else mcnt++;
        1: if (ev_stop) ms = 4;
           else if (ev_wake) begin mcfg = cfg; m_go(first_of(cfg), int'(cfg[3])); end
        2: if (wr_mode) ms = 3;
           else if (stb) begin
             if (mtl > 0) begin
               if (mtp == 2) begin mtp = 0; mtl--; end else mtp++;
             end else if (mbi == NB) begin
               int mb, nb; bit w;
               mcfg = cfg; mb = int'(cfg[2:0]);
               w = (mb != 0) && (mblk >= mb);
               nb = (mb == 0) ? 0 : (w ? 1 : mblk + 1);
               m_go(nb, int'(cfg[3]) + ((w && cfg[4]) ? 2 : 0));
             end else mbi++;
           end
        3: if (ev_stop) ms = 4;
           else if (ev_err || ev_wake) begin mcfg = cfg; m_go(first_of(cfg), int'(cfg[3])); end
           else if (ev_abort) begin mcfg = cfg; m_go(int'(paddr), int'(cfg[3])); end
           else if (ev_done) m_go(int'(paddr), int'(mcfg[3] | mcfg[4]));
        default: ;
      endcase
    end
  end

  // compare away from the active edge
  initial forever begin
    @(negedge clk); #5;
    if (rst_n && !done) begin
      bit run, e_term, e_data, ok;
      run    = (ms == 2);
      e_term = run && (mtl > 0);
      e_data = run ? ((mtl > 0) ? (mtp == 0) : mem[mblk][mbi]) : 1'b0;
      ok = (mod_en == run) && (term == e_term) && (data == e_data) && (cfg_o == mcfg) &&
           (!run || ((int'(blk_addr) == mblk) && (int'(bit_idx) == mbi)));
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s t=%0t act mod=%0b blk=%0d bit=%0d term=%0b data=%0b cfg=%h exp mod=%0b blk=%0d bit=%0d term=%0b data=%0b cfg=%h",
                 req, $time, mod_en, blk_addr, bit_idx, term, data, cfg_o,
                 run, mblk, mbi, e_term, e_data, mcfg);
      end
    end
  end

  // bit strobe: one pulse every four clocks
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      stb = (k % 4 == 3);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 err, 1 wake, 2 done, 3 abort, 4 stop
  task automatic do_write(input int kind, input logic [2:0] a);
    @(negedge clk); wr_mode = 1'b1; paddr = a;
    wait_clk(12);
    ev_err = (kind == 0); ev_wake = (kind == 1); ev_done = (kind == 2);
    ev_abort = (kind == 3); ev_stop = (kind == 4);
    @(negedge clk);
    {ev_err, ev_wake, ev_done, ev_abort, ev_stop} = '0;
    wr_mode = 1'b0;
  endtask

  task automatic do_reset(input logic [5:0] c);
    @(negedge clk); rst_n = 1'b0; cfg = c;
    wait_clk(3);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      mem[i] = 33'h1_3579_BDF1 ^ ({i[2:0], i[2:0], 27'h0} | 33'(i * 32'h0919_5A3C));
    // R1: reset state and restart of loading
    req = "R1";
    do_reset(6'b000_010);
    #5;
    checks++;
    if (mod_en !== 1'b0 || term !== 1'b0 || data !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs act mod=%0b term=%0b data=%0b exp 0 0 0", mod_en, term, data);
    end
    wait_clk(100);
    wr_mode = 1'b1; wait_clk(3); wr_mode = 1'b0;
    wait_clk(250);
    req = "R2"; wait_clk(60);
    req = "R3"; wait_clk(200);
    req = "R4"; wait_clk(300);
    req = "R5"; cfg = 6'b001_011; wait_clk(200);
    req = "R6"; wait_clk(300);
    req = "R7"; cfg = 6'b011_011; wait_clk(900);
    req = "R4"; cfg = 6'b011_000; wait_clk(600);
    req = "R10"; cfg = 6'b000_100; do_write(0, 3'd0); wait_clk(300);
    cfg = 6'b001_100; wait_clk(300);
    req = "R11"; cfg = 6'b000_110; do_write(2, 3'd5); wait_clk(400);
    req = "R12"; cfg = 6'b011_010; do_write(3, 3'd3); wait_clk(300);
    req = "R9"; do_write(4, 3'd0); wait_clk(300);
    req = "R8"; do_reset(6'b101_010); wait_clk(500);
    do_write(1, 3'd0); wait_clk(300);
    req = "R9"; do_write(4, 3'd0); wait_clk(200);
    req = "R8"; do_reset(6'b100_011); wait_clk(400);
    do_write(4, 3'd0); wait_clk(200);
    do_write(1, 3'd0); wait_clk(100);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule